// File: doc/BRIEF.md
# Selectable Watchdog Timer

This block supervises a host processor that must prove it is alive by sending restart strobes at regular intervals. It counts pulses of a slow time-base tick and, when a whole interval passes without a restart strobe, raises a level watchdog output and emits a single-cycle fault pulse for a fault-capture register elsewhere in the supervisor.

A two-bit period code selects one of three intervals (long, medium, short) or turns the watchdog off. The code comes from nonvolatile control bits in another block, so the chosen interval survives power cycling. The "off" code is the default that parts leave the factory with. The tick count of each interval is a parameter. With a 1 ms tick the defaults give 1.4 s, 200 ms and 25 ms. The system reset from the supervisor clears the timer.

Top module: `sel_watchdog`

## Requirements
- R1: While `sysRst` is high, `wdOut` and `faultPulse` are low on every following cycle and the tick count is cleared, so after release a full interval of ticks is needed before a timeout.
- R2: With `periodCode` = 2'b00 and no restart, `wdOut` rises on the clock edge that samples the TICKS_LONG-th tick counted since the last clear.
- R3: With `periodCode` = 2'b01 the same holds with TICKS_MID ticks.
- R4: With `periodCode` = 2'b10 the same holds with TICKS_SHORT ticks.
- R5: With `periodCode` = 2'b11 the watchdog is off. `wdOut` is low from the next edge onward, no `faultPulse` is produced and the count stays cleared.
- R6: A cycle with `kick` high clears the count and makes `wdOut` low on the next edge. If the kick arrives in the same cycle as the final tick of an interval, the kick wins and no timeout occurs.
- R7: A cycle in which `periodCode` differs from its value in the previous cycle clears the count. The tick in that cycle is not counted.
- R8: Once high, `wdOut` stays high until a kick, a reset or the off code. While `wdOut` is high, ticks do not start a new interval.
- R9: `faultPulse` is high for exactly one cycle per timeout, on the same edge where `wdOut` rises.
- R10: Only cycles with `tick` high advance the count. Cycles without a tick leave the timeout point unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRst | input | 1 | Synchronous system reset, active high |
| tick | input | 1 | Time-base pulse, one cycle wide |
| kick | input | 1 | Restart strobe from the host |
| periodCode | input | 2 | Interval select: 00 long, 01 medium, 10 short, 11 off |
| wdOut | output | 1 | Watchdog output, high after a timeout |
| faultPulse | output | 1 | One-cycle pulse per timeout, sets the fault flag |

## Verification
Every result of this block is due exactly one edge after the input cycle that causes it. A timeout appears on the edge that samples the last tick, and a kick, a code change, the off code or a reset acts on the next edge. The driver sets inputs on the falling edge. It queues, tagged with the index of the following cycle, the output pair (`wdOut`, `faultPulse`) that the requirements call for. The monitor compares that pair on the next falling edge, so every comparison falls in the cycle where the registered outputs have just settled. Interval lengths are derived from the bench's own parameter values and cover dense ticks, sparse ticks, a kick on the final tick, a code change in mid-interval, disabling while timed out and a reset in mid-interval.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PER_LONG  = 2'b00,
    PER_MID   = 2'b01,
    PER_SHORT = 2'b10,
    PER_OFF   = 2'b11
  } perCode_t;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;

endpackage

// File: rtl/sel_watchdog_dp.sv
module sel_watchdog_dp
  import wdt_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 200,
  parameter int TICKS_SHORT = 25
) (
  input  logic       clk,
  input  logic       sysRst,
  input  cntStrobe_t strobe,
  input  logic [1:0] periodCode,
  output logic       atLimit
);

  localparam int CNT_W = $clog2(TICKS_LONG + 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(TICKS_LONG - 1);
  localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(TICKS_MID - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(TICKS_SHORT - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastIdx;

  always_comb begin
    case (perCode_t'(periodCode))
      PER_LONG:  lastIdx = LAST_LONG;
      PER_MID:   lastIdx = LAST_MID;
      PER_SHORT: lastIdx = LAST_SHORT;
      default:   lastIdx = '1;
    endcase
  end

  assign atLimit = (cnt == lastIdx);

  always_ff @(posedge clk) begin
    if (sysRst)          cnt <= '0;
    else if (strobe.clr) cnt <= '0;
    else if (strobe.inc) cnt <= cnt + 1'b1;
  end

  // R1
  rst_clears_cnt_chk: assert property (@(posedge clk) sysRst |=> (cnt == '0));

  // R7
  clr_empties_cnt_chk: assert property (@(posedge clk) disable iff (sysRst)
    strobe.clr |=> (cnt == '0));

  // R10
  idle_holds_cnt_chk: assert property (@(posedge clk) disable iff (sysRst)
    (!strobe.clr && !strobe.inc) |=> $stable(cnt));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (sysRst)
    cnt < CNT_W'(TICKS_LONG));

endmodule

// File: rtl/sel_watchdog_ctrl.sv
module sel_watchdog_ctrl
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       sysRst,
  input  logic       tick,
  input  logic       kick,
  input  logic [1:0] periodCode,
  input  logic       atLimit,
  output cntStrobe_t strobe,
  output logic       wdOut,
  output logic       faultPulse
);

  logic [1:0] prevCode;
  logic       disabled;
  logic       codeChg;
  logic       expire;

  assign disabled = (perCode_t'(periodCode) == PER_OFF);
  assign codeChg  = (periodCode != prevCode);
  assign expire   = tick && atLimit && !disabled && !codeChg && !kick && !wdOut;

  always_comb begin
    strobe.clr = kick || codeChg || disabled || expire || wdOut;
    strobe.inc = tick && !strobe.clr;
  end

  always_ff @(posedge clk) begin
    prevCode <= periodCode;
    if (sysRst) begin
      wdOut      <= 1'b0;
      faultPulse <= 1'b0;
    end else begin
      faultPulse <= expire;
      if (kick || disabled) wdOut <= 1'b0;
      else if (expire)      wdOut <= 1'b1;
    end
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) sysRst |=> (!wdOut && !faultPulse));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (sysRst)
    faultPulse |=> !faultPulse);

  // R9
  pulse_with_rise_chk: assert property (@(posedge clk) disable iff (sysRst)
    $rose(wdOut) |-> faultPulse);

  // R5
  off_silent_chk: assert property (@(posedge clk) disable iff (sysRst)
    disabled |=> (!wdOut && !faultPulse));

  // R6
  kick_clears_chk: assert property (@(posedge clk) disable iff (sysRst)
    kick |=> !wdOut);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (sysRst)
    (wdOut && !kick && !disabled) |=> wdOut);

endmodule

// File: rtl/sel_watchdog.sv
module sel_watchdog
  import wdt_pkg::*;
#(
  parameter int TICKS_LONG  = 1400,
  parameter int TICKS_MID   = 200,
  parameter int TICKS_SHORT = 25
) (
  input  logic       clk,
  input  logic       sysRst,
  input  logic       tick,
  input  logic       kick,
  input  logic [1:0] periodCode,
  output logic       wdOut,
  output logic       faultPulse
);

  cntStrobe_t strobe;
  logic       atLimit;

  sel_watchdog_ctrl u_ctrl (
    .clk        (clk),
    .sysRst     (sysRst),
    .tick       (tick),
    .kick       (kick),
    .periodCode (periodCode),
    .atLimit    (atLimit),
    .strobe     (strobe),
    .wdOut      (wdOut),
    .faultPulse (faultPulse)
  );

  sel_watchdog_dp #(
    .TICKS_LONG  (TICKS_LONG),
    .TICKS_MID   (TICKS_MID),
    .TICKS_SHORT (TICKS_SHORT)
  ) u_dp (
    .clk        (clk),
    .sysRst     (sysRst),
    .strobe     (strobe),
    .periodCode (periodCode),
    .atLimit    (atLimit)
  );

endmodule

// File: tb/sel_watchdog_bench.sv
module sel_watchdog_bench;

  localparam int T_LONG  = 20;
  localparam int T_MID   = 7;
  localparam int T_SHORT = 3;

  logic       clk = 1'b0;
  logic       sysRst = 1'b1;
  logic       tick = 1'b0;
  logic       kick = 1'b0;
  logic [1:0] periodCode = 2'b00;
  logic       wdOut;
  logic       faultPulse;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  typedef struct {
    int    at;
    logic  wd;
    logic  fp;
    string tag;
  } expItem_t;

  expItem_t expQ[$];

  sel_watchdog #(
    .TICKS_LONG  (T_LONG),
    .TICKS_MID   (T_MID),
    .TICKS_SHORT (T_SHORT)
  ) u_sel_watchdog (
    .clk        (clk),
    .sysRst     (sysRst),
    .tick       (tick),
    .kick       (kick),
    .periodCode (periodCode),
    .wdOut      (wdOut),
    .faultPulse (faultPulse)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations on the falling edge of their cycle
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (wdOut !== e.wd || faultPulse !== e.fp) begin
        errors++;
        $display("FAIL %s cyc %0d: wdOut/faultPulse = %b/%b expected %b/%b",
                 e.tag, cyc, wdOut, faultPulse, e.wd, e.fp);
      end
    end
  end

  // one cycle of stimulus; outputs due after the next rising edge
  task automatic step(input logic t, input logic k, input logic [1:0] code,
                      input logic r, input logic ew, input logic ef, input string tag);
    expItem_t e;
    @(negedge clk);
    tick = t; kick = k; periodCode = code; sysRst = r;
    e.at = cyc + 1; e.wd = ew; e.fp = ef; e.tag = tag;
    expQ.push_back(e);
  endtask

  // n dense ticks from a cleared count; timeout on the last one
  task automatic interval(input int n, input logic [1:0] code, input string tag);
    for (int i = 0; i < n; i++)
      step(1'b1, 1'b0, code, 1'b0, (i == n-1), (i == n-1), tag);
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, "R1");
    // R2: long interval right after reset
    interval(T_LONG, 2'b00, "R2");
    // R8: held high, pulse gone, ticks ignored
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, "R8");
    // R6: kick clears
    step(1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, "R6");
    // R3: code change cycle, then medium interval
    step(1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, "R7");
    interval(T_MID, 2'b01, "R3");
    step(1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, "R6");
    // R4: short interval
    step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R7");
    interval(T_SHORT, 2'b10, "R4");
    step(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R6");
    // R10: sparse ticks
    step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R10");
    step(1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 1'b1, "R10");
    step(1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, "R9");
    step(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R6");
    // R6: kick on the final tick wins
    for (int i = 0; i < T_SHORT - 1; i++) step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R6");
    interval(T_SHORT, 2'b10, "R6");
    step(1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, "R6");
    // R7: code change in mid-interval restarts it
    for (int i = 0; i < T_SHORT - 1; i++) step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R7");
    step(1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, "R7");
    interval(T_MID, 2'b01, "R7");
    // R5: off code drops a held output and stays silent
    step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, "R5");
    for (int i = 0; i < 2 * T_LONG; i++) step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0, "R5");
    // R1: reset in mid-interval, then a full interval is needed
    step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R7");
    for (int i = 0; i < T_SHORT - 1; i++) step(1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, "R1");
    interval(T_SHORT, 2'b10, "R1");
    step(1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 1'b0, "R9");
    // drain
    @(negedge clk); tick = 1'b0; kick = 1'b0;
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, cycle %0d expected below 5000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule